// File: doc/BRIEF.md
# Line Brown-out and Fault Latch Supervisor

This block is the digital supervisor of an offline switching controller. It watches two comparator flags on the rectified line and two on a protection pin. From them it decides whether the power stage may switch. When the line drops, the block does not stop switching at once. It waits until the low-line flag has stayed set for a blanking window counted in prescaled ticks. Once stopped, it resumes only after the line climbs back over the higher restart threshold. The gap between the two thresholds gives the supervisor hysteresis.

On each recovery the supervisor sends a one-cycle general-reset pulse, and that pulse clears any latched fault. An over-voltage indication on the protection pin latches the controller off until the next recovery. An over-temperature indication blocks switching only for as long as it is present. The comparators, the threshold references and the start-up current source are outside this block; each one reaches it as a single-bit flag, and all timing is taken from a tick strobe.

Top module: `line_fault_supervisor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `run_en`, `latched_off` and `gen_reset` are 0. The block leaves reset in the stopped (line-low) state.
- R2: In the stopped state the block stays stopped, with `run_en` at 0, whenever `line_rise_ok` is 0. This holds for any `line_fall_low` value and any `tick`.
- R3: If `line_rise_ok` is sampled at 1 in the stopped state, `gen_reset` is 1 for exactly the following cycle. `run_en` is 0 during that pulse and goes to 1 in the cycle after it when no fault blocks it.
- R4: While running, switching stops once `line_fall_low` has been 1 on every cycle across BLANK_TICKS tick strobes. `run_en` goes to 0 at the clock edge that samples the final tick.
- R5: When `line_fall_low` is sampled at 0 on any cycle, the blanking count returns to zero. A following low-line episode then needs a full BLANK_TICKS ticks again.
- R6: If `fault_ovp` is sampled at 1, `latched_off` is 1 and `run_en` is 0 from the next cycle. Both hold after `fault_ovp` returns to 0, until a general reset.
- R7: In the cycle after the `gen_reset` pulse, `latched_off` is 0 even when `fault_ovp` is 1 in the pulse cycle, because clearing takes priority over setting. If `fault_ovp` is still 1, the latch sets again one cycle later.
- R8: If `fault_otp` is sampled at 1, `run_en` is 0 in the next cycle and `latched_off` is not set. `run_en` returns to 1 in the cycle after `fault_otp` is sampled at 0 again.
- R9: A cycle with `tick` at 0 does not advance the blanking count, even when `line_fall_low` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe from the timing prescaler |
| line_rise_ok | input | 1 | Line is above the restart threshold |
| line_fall_low | input | 1 | Line is below the stop threshold |
| fault_ovp | input | 1 | Protection pin is above the over-voltage level |
| fault_otp | input | 1 | Protection pin is below the over-temperature level |
| run_en | output | 1 | Power stage may switch (registered) |
| latched_off | output | 1 | Over-voltage latch is set (registered) |
| gen_reset | output | 1 | One-cycle general reset on line recovery (registered) |

## Verification
The bench checks the blanking count at its exact edge. A counter that is off by one would stop a tick too early or too late, and one that pauses instead of clearing on a brief line return would stop early on the second low-line episode. It drives the hysteresis band while stopped to catch a design that restarts on the falling flag alone. It holds over-voltage across the recovery pulse: a latch whose set beats its clear would never release, and one that ignores the pulse would stay latched after recovery. It also releases over-temperature to confirm that this fault does not latch.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    LS_LOW  = 2'd0,
    LS_GRST = 2'd1,
    LS_OK   = 2'd2
  } line_st_t;
endpackage

// File: rtl/lfs_blank_timer.sv
module lfs_blank_timer #(
  parameter int BLANK_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic below,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(BLANK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    expire = 1'b0;
    cnt_d  = cnt_q;
    if (!arm || !below) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        expire = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !below |=> cnt_q == '0);
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && below && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/lfs_fault_latch.sv
module lfs_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic latch_q,
  output logic latch_d
);
  always_comb begin
    if (clr)      latch_d = 1'b0;
    else if (set) latch_d = 1'b1;
    else          latch_d = latch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_d;
  end

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !clr) |=> latch_q);
  // R6
  latch_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> latch_q);
  // R7
  latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !latch_q);
endmodule

// File: rtl/lfs_line_fsm.sv
module lfs_line_fsm
  import lfs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rise_ok,
  input  logic     expire,
  output line_st_t st_q,
  output line_st_t st_d
);
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LS_LOW:  if (rise_ok) st_d = LS_GRST;
      LS_GRST: st_d = LS_OK;
      LS_OK:   if (expire) st_d = LS_LOW;
      default: st_d = LS_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LS_LOW;
    else     st_q <= st_d;
  end

  // R3
  grst_single_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_GRST) |=> (st_q == LS_OK));
  // R2
  no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_LOW) |=> (st_q != LS_OK));
  // R2
  stay_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_LOW && !rise_ok) |=> (st_q == LS_LOW));
endmodule

// File: rtl/line_fault_supervisor.sv
module line_fault_supervisor
  import lfs_pkg::*;
#(
  parameter int BLANK_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_rise_ok,
  input  logic line_fall_low,
  input  logic fault_ovp,
  input  logic fault_otp,
  output logic run_en,
  output logic latched_off,
  output logic gen_reset
);
  line_st_t st_q;
  line_st_t st_d;
  logic     expire;
  logic     latch_d;
  logic     run_q;

  lfs_blank_timer #(.BLANK_TICKS(BLANK_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (st_q == LS_OK),
    .below  (line_fall_low),
    .tick   (tick),
    .expire (expire)
  );

  lfs_line_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .rise_ok (line_rise_ok),
    .expire  (expire),
    .st_q    (st_q),
    .st_d    (st_d)
  );

  lfs_fault_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .set     (fault_ovp),
    .clr     (st_q == LS_GRST),
    .latch_q (latched_off),
    .latch_d (latch_d)
  );

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= (st_d == LS_OK) && !latch_d && !fault_ovp && !fault_otp;
  end

  assign run_en    = run_q;
  assign gen_reset = (st_q == LS_GRST);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    gen_reset |=> !gen_reset);
  // R3
  no_run_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    gen_reset |-> !run_en);
  // R8
  otp_block_chk: assert property (@(posedge clk) disable iff (rst)
    fault_otp |=> !run_en);
  // R6
  ovp_block_chk: assert property (@(posedge clk) disable iff (rst)
    fault_ovp |=> !run_en);
  // R4
  stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_OK && st_d == LS_LOW) |-> (line_fall_low && tick));
endmodule

// File: tb/line_fault_supervisor_bench.sv
`timescale 1ns/100ps
module line_fault_supervisor_bench;
  localparam int BT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, rise = 1'b0, fall = 1'b0, ovp = 1'b0, otp = 1'b0;
  logic run_en, latched_off, gen_reset;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  line_fault_supervisor #(.BLANK_TICKS(BT)) u_line_fault_supervisor (
    .clk(clk), .rst(rst), .tick(tick), .line_rise_ok(rise),
    .line_fall_low(fall), .fault_ovp(ovp), .fault_otp(otp),
    .run_en(run_en), .latched_off(latched_off), .gen_reset(gen_reset)
  );

  // {requirement, inputs {rise,fall,ovp,otp,tick}, expected {run,latched,grst}}
  localparam logic [11:0] VEC [25] = '{
    {4'd2, 5'b00000, 3'b000},  // R2 stopped, band
    {4'd2, 5'b00001, 3'b000},  // R2 tick in band, still stopped
    {4'd3, 5'b10000, 3'b001},  // R3 pulse
    {4'd3, 5'b10000, 3'b100},  // R3 run after pulse
    {4'd3, 5'b00000, 3'b100},
    {4'd8, 5'b00010, 3'b000},  // R8 otp blocks
    {4'd8, 5'b00000, 3'b100},  // R8 released, no latch
    {4'd6, 5'b00100, 3'b010},  // R6 ovp latches
    {4'd6, 5'b00000, 3'b010},  // R6 held
    {4'd4, 5'b01001, 3'b010},  // R4 tick 1
    {4'd9, 5'b01001, 3'b010},  // R9 tick 2
    {4'd9, 5'b01000, 3'b010},  // R9 no tick
    {4'd4, 5'b01001, 3'b010},  // R4 tick 3
    {4'd4, 5'b01001, 3'b010},  // R4 tick 4 -> stop
    {4'd2, 5'b00000, 3'b010},  // R2 band, stopped
    {4'd3, 5'b10000, 3'b011},  // R3 pulse, latch still set
    {4'd7, 5'b10000, 3'b100},  // R7 latch cleared, run
    {4'd5, 5'b01001, 3'b100},  // R5 tick 1
    {4'd5, 5'b00001, 3'b100},  // R5 fall gone, count cleared
    {4'd5, 5'b01001, 3'b100},
    {4'd4, 5'b01001, 3'b100},
    {4'd4, 5'b01001, 3'b100},
    {4'd4, 5'b01001, 3'b000},  // R4 4th tick after clear
    {4'd7, 5'b10100, 3'b011},  // R7 ovp while stopped, pulse
    {4'd7, 5'b00000, 3'b100}   // R7 cleared by pulse
  };

  task automatic drive(input logic [4:0] v);
    @(negedge clk);
    {rise, fall, ovp, otp, tick} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [2:0] got, input logic [2:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got run/latch/grst=%b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({run_en, latched_off, gen_reset}, 3'b000, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk({run_en, latched_off, gen_reset}, 3'b000, "R1 after release");

    for (int i = 0; i < 25; i++) begin
      drive(VEC[i][7:3]);
      chk({run_en, latched_off, gen_reset}, VEC[i][2:0],
          $sformatf("R%0d table row %0d", VEC[i][11:8], i));
    end

    // R5: two windows of BT-1 ticks split by one line-good cycle never stop
    drive(5'b10000);
    drive(5'b00000);
    chk({run_en, latched_off, gen_reset}, 3'b100, "R3 restart before R5");
    for (int k = 0; k < BT - 1; k++) drive(5'b01001);
    drive(5'b00000);
    for (int k = 0; k < BT - 1; k++) drive(5'b01001);
    chk({run_en, latched_off, gen_reset}, 3'b100, "R5 split window");
    drive(5'b01001);
    chk({run_en, latched_off, gen_reset}, 3'b000, "R4 final tick stops");

    // R7: ovp held across recovery pulse
    drive(5'b10100);
    chk({run_en, latched_off, gen_reset}, 3'b011, "R7 pulse with ovp");
    drive(5'b00100);
    chk({run_en, latched_off, gen_reset}, 3'b000, "R7 clear wins");
    drive(5'b00100);
    chk({run_en, latched_off, gen_reset}, 3'b010, "R7 relatch");
    drive(5'b00000);
    chk({run_en, latched_off, gen_reset}, 3'b010, "R6 latch holds");

    // R1: reset while latched
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk({run_en, latched_off, gen_reset}, 3'b000, "R1 reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    drive(5'b00001);
    chk({run_en, latched_off, gen_reset}, 3'b000, "R1 stopped after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule